// File: doc/BRIEF.md
# Four-Function Arithmetic-Logic Unit

A purely combinational arithmetic-logic unit of configurable width. Two operands are presented together with a two-bit operation code. The unit forms a sum or difference, a bitwise AND and a bitwise OR at the same time. An output multiplexer, addressed by the operation code, then passes one of them to the result. A carry flag and a zero flag accompany the result.

Addition and subtraction share one adder. The low bit of the operation code inverts the second operand and supplies the adder's carry-in. Subtraction is therefore the first operand plus the two's complement of the second. A build-time parameter selects the adder structure. One choice is a bit-serial carry chain. The other is four-bit carry-lookahead groups whose group generate and propagate terms are chained between groups. Any width is accepted, because the lookahead variant pads internally to a multiple of four.

Top module: `alu_four_func`

## Requirements
- R1: Code 2'b00 gives o_c = (i_a + i_b) mod 2^WIDTH, and o_carry is the carry out of bit WIDTH-1 of that sum.
- R2: Code 2'b01 gives o_c = (i_a - i_b) mod 2^WIDTH, and o_carry is the carry out of i_a + ~i_b + 1, which is 1 exactly when i_a >= i_b unsigned.
- R3: Code 2'b10 gives o_c = i_a AND i_b, bit by bit.
- R4: Code 2'b11 gives o_c = i_a OR i_b, bit by bit.
- R5: o_carry is 0 for codes 2'b10 and 2'b11, whatever the operands.
- R6: o_zero is 1 exactly when every bit of o_c is 0, for every code.
- R7: The unit holds no state: the outputs follow the current inputs without any clock edge.
- R8: The ripple and lookahead adder variants give identical outputs, including at widths that are not a multiple of four.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| i_a | input | WIDTH | First operand |
| i_b | input | WIDTH | Second operand (subtrahend for code 01) |
| i_op | input | 2 | Operation code: 00 add, 01 subtract, 10 AND, 11 OR |
| o_c | output | WIDTH | Selected result |
| o_carry | output | 1 | Adder carry out for 00/01, else 0 |
| o_zero | output | 1 | High when o_c is all zeros |

## Verification
The bench targets the carry boundaries. All-ones plus one must wrap to zero with carry set and zero flag high; a unit that dropped the carry-in or the top carry would show a nonzero sum or a clear carry. Equal operands under subtraction must give zero with carry 1, and zero minus one must give all ones with carry 0; a design that inverted B without asserting carry-in would be off by one in both. Logic codes are driven with operands whose sum overflows, so that a carry leaking from the adder through the multiplexer appears on o_carry. The same vectors go to a ten-bit lookahead instance and an eight-bit ripple instance, which exposes mistakes in group padding or in the lookahead terms.

// File: rtl/alu_pkg.sv
package alu_pkg;
   typedef enum logic [1:0] {
      OP_ADD = 2'b00,
      OP_SUB = 2'b01,
      OP_AND = 2'b10,
      OP_OR  = 2'b11
   } alu_op_e;

   typedef enum int {
      ADDER_RIPPLE = 0,
      ADDER_CLA    = 1
   } adder_kind_e;

   localparam int CLA_GROUP = 4;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int                  WIDTH      = 8,
   parameter alu_pkg::adder_kind_e ADDER_KIND = alu_pkg::ADDER_CLA
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   localparam int GRP    = alu_pkg::CLA_GROUP;
   localparam int NGRP   = (WIDTH + GRP - 1) / GRP;
   localparam int PADW   = NGRP * GRP;

   if (WIDTH < 1) begin : g_bad_width
      $error("alu_addsub: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] b_eff;
   assign b_eff = b ^ {WIDTH{sub}};

   if (ADDER_KIND == alu_pkg::ADDER_RIPPLE) begin : g_ripple
      logic [WIDTH:0] cy;
      assign cy[0] = sub;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign sum[i]  = a[i] ^ b_eff[i] ^ cy[i];
         assign cy[i+1] = (a[i] & b_eff[i]) | (a[i] & cy[i]) | (b_eff[i] & cy[i]);
      end
      assign cout = cy[WIDTH];
   end else begin : g_cla
      logic [PADW-1:0] ap, bp, gen, prop, hsum, cin_bit;
      logic [NGRP:0]   gcy;
      logic [NGRP-1:0] ggen, gprop;

      assign ap   = PADW'(a);
      assign bp   = PADW'(b_eff);
      assign gen  = ap & bp;
      assign prop = ap | bp;
      assign hsum = ap ^ bp;
      assign gcy[0] = sub;

      for (genvar k = 0; k < NGRP; k++) begin : g_grp
         logic [GRP-1:0] gg, pp;
         assign gg = gen[k*GRP +: GRP];
         assign pp = prop[k*GRP +: GRP];

         // bit carries of the group, each as a flat sum of products
         always_comb begin
            for (int j = 0; j < GRP; j++) begin
               logic cj, t;
               cj = 1'b0;
               for (int m = 0; m < j; m++) begin
                  t = gg[m];
                  for (int n = m + 1; n < j; n++) t = t & pp[n];
                  cj = cj | t;
               end
               t = gcy[k];
               for (int n = 0; n < j; n++) t = t & pp[n];
               cin_bit[k*GRP + j] = cj | t;
            end
         end

         // group generate / propagate
         always_comb begin
            logic acc, t;
            acc = 1'b0;
            for (int m = 0; m < GRP; m++) begin
               t = gg[m];
               for (int n = m + 1; n < GRP; n++) t = t & pp[n];
               acc = acc | t;
            end
            ggen[k]  = acc;
            gprop[k] = &pp;
         end

         assign gcy[k+1] = ggen[k] | (gprop[k] & gcy[k]);
      end

      logic [PADW-1:0] psum;
      assign psum = hsum ^ cin_bit;
      assign sum  = psum[WIDTH-1:0];

      if (PADW == WIDTH) begin : g_exact
         assign cout = gcy[NGRP];
      end else begin : g_padded
         // carry into the first padding bit is the true carry out
         assign cout = cin_bit[WIDTH];
      end
   end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] and_out,
   output logic [WIDTH-1:0] or_out
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign and_out[i] = a[i] & b[i];
      assign or_out[i]  = a[i] | b[i];
   end
endmodule

// File: rtl/alu_outmux.sv
module alu_outmux #(
   parameter int WIDTH = 8
) (
   input  alu_pkg::alu_op_e  op,
   input  logic [WIDTH-1:0]  arith,
   input  logic              arith_cout,
   input  logic [WIDTH-1:0]  and_in,
   input  logic [WIDTH-1:0]  or_in,
   output logic [WIDTH-1:0]  res,
   output logic              carry,
   output logic              zero
);
   always_comb begin
      unique case (op)
         alu_pkg::OP_ADD,
         alu_pkg::OP_SUB: begin res = arith;  carry = arith_cout; end
         alu_pkg::OP_AND: begin res = and_in; carry = 1'b0;       end
         default:         begin res = or_in;  carry = 1'b0;       end
      endcase
   end

   assign zero = ~|res;
endmodule

// File: rtl/alu_four_func.sv
module alu_four_func #(
   parameter int                   WIDTH      = 8,
   parameter alu_pkg::adder_kind_e ADDER_KIND = alu_pkg::ADDER_CLA
) (
   input  logic [WIDTH-1:0] i_a,
   input  logic [WIDTH-1:0] i_b,
   input  logic [1:0]       i_op,
   output logic [WIDTH-1:0] o_c,
   output logic             o_carry,
   output logic             o_zero
);
   import alu_pkg::*;

   alu_op_e          op;
   logic [WIDTH-1:0] arith, and_v, or_v;
   logic             arith_cout;

   assign op = alu_op_e'(i_op);

   alu_addsub #(.WIDTH(WIDTH), .ADDER_KIND(ADDER_KIND)) u_addsub (
      .a    (i_a),
      .b    (i_b),
      .sub  (i_op[0]),
      .sum  (arith),
      .cout (arith_cout)
   );

   alu_logic #(.WIDTH(WIDTH)) u_logic (
      .a       (i_a),
      .b       (i_b),
      .and_out (and_v),
      .or_out  (or_v)
   );

   alu_outmux #(.WIDTH(WIDTH)) u_mux (
      .op         (op),
      .arith      (arith),
      .arith_cout (arith_cout),
      .and_in     (and_v),
      .or_in      (or_v),
      .res        (o_c),
      .carry      (o_carry),
      .zero       (o_zero)
   );

   always_comb begin
      if (op == OP_ADD) begin
         AST_ADD_RESULT: assert ({o_carry, o_c} == ({1'b0, i_a} + {1'b0, i_b})) else $error("add mismatch"); // R1
      end
      if (op == OP_SUB) begin
         AST_SUB_RESULT: assert (o_c == WIDTH'(i_a - i_b) && o_carry == (i_a >= i_b)) else $error("sub mismatch"); // R2
      end
      if (op == OP_AND) begin
         AST_AND_RESULT: assert (o_c == (i_a & i_b)) else $error("and mismatch"); // R3
      end
      if (op == OP_OR) begin
         AST_OR_RESULT: assert (o_c == (i_a | i_b)) else $error("or mismatch"); // R4
      end
      if (op == OP_AND || op == OP_OR) begin
         AST_LOGIC_NO_CARRY: assert (!o_carry) else $error("carry on logic op"); // R5
      end
   end
endmodule

// File: tb/sim_alu_four_func.sv
module sim_alu_four_func;
   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   typedef struct {
      logic [1:0]  op;
      logic [15:0] a;
      logic [15:0] b;
   } vec_t;

   vec_t q[$];
   int   n_vec  = 0;
   int   n_fail = 0;
   bit   done   = 0;

   logic [15:0] a_bus = '0, b_bus = '0;
   logic [1:0]  op_bus = 2'b00;

   logic [7:0] c0, c2;
   logic [9:0] c1;
   logic       cy0, cy1, cy2, z0, z1, z2;

   alu_four_func #(.WIDTH(8), .ADDER_KIND(alu_pkg::ADDER_CLA)) u0 (
      .i_a(a_bus[7:0]), .i_b(b_bus[7:0]), .i_op(op_bus),
      .o_c(c0), .o_carry(cy0), .o_zero(z0));
   alu_four_func #(.WIDTH(10), .ADDER_KIND(alu_pkg::ADDER_CLA)) u1 (
      .i_a(a_bus[9:0]), .i_b(b_bus[9:0]), .i_op(op_bus),
      .o_c(c1), .o_carry(cy1), .o_zero(z1));
   alu_four_func #(.WIDTH(8), .ADDER_KIND(alu_pkg::ADDER_RIPPLE)) u2 (
      .i_a(a_bus[7:0]), .i_b(b_bus[7:0]), .i_op(op_bus),
      .o_c(c2), .o_carry(cy2), .o_zero(z2));

   // reference: returns {zero, carry, result[15:0]}
   function automatic logic [17:0] model(logic [1:0] op, logic [15:0] a, logic [15:0] b, int w);
      logic [16:0] mask, s;
      logic [15:0] r;
      logic        cy;
      mask = (17'd1 << w) - 17'd1;
      a = a & mask[15:0];
      b = b & mask[15:0];
      case (op)
         2'b00: begin s = {1'b0, a} + {1'b0, b}; cy = s[w]; r = s[15:0] & mask[15:0]; end
         2'b01: begin s = {1'b0, a} + {1'b0, ~b & mask[15:0]} + 17'd1; cy = s[w]; r = s[15:0] & mask[15:0]; end
         2'b10: begin r = a & b; cy = 1'b0; end
         default: begin r = a | b; cy = 1'b0; end
      endcase
      return {(r == 16'd0), cy, r};
   endfunction

   function automatic string req_of(logic [1:0] op);
      case (op)
         2'b00: return "R1";
         2'b01: return "R2";
         2'b10: return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic compare(string who, string tag, logic [1:0] op, logic [17:0] exp,
                          logic [15:0] c, logic cy, logic z);
      string r;
      r = req_of(op);
      if (c !== exp[15:0]) begin
         n_fail++;
         $display("FAIL %s %s%s result op=%b got %h exp %h", r, who, tag, op, c, exp[15:0]);
      end else if (cy !== exp[16]) begin
         n_fail++;
         $display("FAIL %s %s%s carry op=%b got %b exp %b",
                  (op[1] ? "R5" : r), who, tag, op, cy, exp[16]);
      end else if (z !== exp[17]) begin
         n_fail++;
         $display("FAIL R6 %s%s zero op=%b got %b exp %b", who, tag, op, z, exp[17]);
      end
   endtask

   // monitor: pops one item per cycle, samples at the falling edge (R7: no clock into the DUT)
   always @(negedge clk) begin
      if (q.size() > 0) begin
         vec_t v;
         v = q.pop_front();
         n_vec++;
         compare("u0", "", v.op, model(v.op, v.a, v.b, 8),  {8'h0, c0}, cy0, z0);
         compare("u1", " R8 w10", v.op, model(v.op, v.a, v.b, 10), {6'h0, c1}, cy1, z1);
         compare("u2", " R8 ripple", v.op, model(v.op, v.a, v.b, 8),  {8'h0, c2}, cy2, z2);
      end
   end

   task automatic drive(logic [1:0] op, logic [15:0] a, logic [15:0] b);
      vec_t v;
      @(posedge clk);
      #1;
      op_bus = op; a_bus = a; b_bus = b;
      v.op = op; v.a = a; v.b = b;
      q.push_back(v);
   endtask

   initial begin
      // idle state: zeros in, zero flag up, no carry
      drive(2'b00, 16'h0000, 16'h0000);                  // R1 R6
      drive(2'b00, 16'h03FF, 16'h0001);                  // R1 wrap: all ones + 1
      drive(2'b00, 16'h00FF, 16'h00FF);                  // R1 carry with nonzero result
      drive(2'b01, 16'h0055, 16'h0055);                  // R2 equal -> zero, carry 1
      drive(2'b01, 16'h0000, 16'h0001);                  // R2 borrow -> all ones, carry 0
      drive(2'b01, 16'h0080, 16'h007F);                  // R2
      drive(2'b10, 16'h03F0, 16'h020F);                  // R3
      drive(2'b10, 16'h00AA, 16'h0055);                  // R3 R6 zero result
      drive(2'b11, 16'h0000, 16'h0000);                  // R4 R6
      drive(2'b11, 16'h0300, 16'h0011);                  // R4
      drive(2'b10, 16'h03FF, 16'h03FF);                  // R5 sum would overflow
      drive(2'b11, 16'h03FF, 16'h03FF);                  // R5
      for (int i = 0; i < 4; i++) drive(2'(i), 16'h0200, 16'h0200); // R8 padding region
      for (int i = 0; i < 600; i++)
         drive(2'($urandom_range(3)), 16'($urandom), 16'($urandom)); // R1..R4 R6
      @(posedge clk);
      @(posedge clk);
      done = 1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 5000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired: got no completion, expected completion");
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule